// File: doc/BRIEF.md
# Tomasulo-Style Dynamic Scheduling Core

This block is the out-of-order execution heart of a small floating-point style datapath. Operations enter one at a time, in program order, through an issue port. Each operation gives an opcode, a destination register and two source registers. On entry it takes a free reservation slot of the matching unit class. There are short-unit slots for add and subtract, and long-unit slots for multiply and divide. Each source is either read as a value right away or replaced by the tag of the slot that will produce it. The destination register is then marked as owned by the new slot's tag.

A slot starts its countdown once both operands are present. It keeps watching the shared result bus until then, so it can pick up values whose tags it is waiting on. When the countdown ends, the slot asks for the single result bus. The granted slot drives its tag and value to every waiting slot and to the register file in the same cycle, and it is then released. The arithmetic is unsigned 32-bit integer arithmetic on the register contents. The scheduling is the object of the block, not the number format.

Top module: `tomasulo_core`

## Requirements
- R1: After reset, every slot is free, the result bus is idle, `iss_ready` is high for both unit classes, and register k reads back the value k with no pending writer.
- R2: The opcode selects the result. 0 gives a+b, 1 gives a-b, 2 gives the low 32 bits of a*b, and 3 gives the unsigned quotient a/b, with a zero divisor giving all ones. Every broadcast value equals the result of running the issued stream in program order.
- R3: If both operands are available at issue, the result appears on the bus L+1 cycles after the issue edge. L is 2 for add and subtract, 10 for multiply and 40 for divide.
- R4: Tags 1 to 3 name the short-unit slots and tags 4 to 5 name the long-unit slots. Issue takes the lowest-numbered free slot of the needed class and reports its tag on `iss_tag`. With no such slot free, `iss_ready` is low and nothing is issued.
- R5: A source with a pending writer is held as that writer's tag. The slot takes the value when that tag is broadcast, and it starts execution only once both operands hold values.
- R6: When a tag is broadcast, each register whose pending writer is that tag takes the value and loses its pending mark.
- R7: Issue makes the new slot the pending writer of its destination. An earlier writer's later broadcast then leaves that register unchanged.
- R8: At most one slot drives the bus per cycle. A finished short-unit slot wins over a long-unit slot, and a lower tag wins within a class. A slot that loses keeps its result and drives it on a later cycle.
- R9: An operation issued in the cycle in which its source's tag is on the bus takes the bus value directly and starts at once.
- R10: A source with no pending writer is copied at issue. A later write to that register does not change the copied operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 div |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | A slot of the class needed by `iss_op` is free |
| iss_tag | output | 3 | Tag that the offered operation receives (0 when not ready) |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 3 | Tag of the slot driving the bus |
| cdb_value | output | 32 | Result value on the bus |
| rd_addr | input | 3 | Register inspection address |
| rd_value | output | 32 | Current value of register `rd_addr` |
| rd_busy | output | 1 | Register `rd_addr` has a pending writer |

## Verification
The bench uses the default parameters: three short-unit slots, two long-unit slots, eight registers and latencies of 2, 10 and 40 cycles. A single 40-cycle divide then holds a long-unit slot for long enough to fill every short-unit slot behind it and to drive the stall. An 8-cycle gap between a multiply and an add makes both finish on the same edge, which exercises bus arbitration. A producer-consumer pair spaced three cycles apart lands the consumer's issue on the producer's broadcast cycle. A scoreboard checks every broadcast value against a sequential model of the issued stream.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } fu_op_e;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_WAIT = 2'd1,
    SL_EXEC = 2'd2,
    SL_DONE = 2'd3
  } slot_st_e;

  // Result of one operation on two operand values.
  function automatic logic [DATA_W-1:0] fu_compute(input fu_op_e op,
                                                   input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      default: r = (b == '0) ? '1 : (a / b);
    endcase
    return r;
  endfunction

  // Long-unit operations carry a 1 in the high opcode bit.
  function automatic logic fu_is_long(input fu_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/cdb_arbiter.sv
module cdb_arbiter #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Fixed priority: lowest index wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    grant = any ? (N'(1) << idx) : '0;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  p_grant_when_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $countones(grant) == 1);

endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import tomasulo_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 2,
  localparam int LAT_MAX = (LAT_LO > LAT_HI) ? LAT_LO : LAT_HI,
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  fu_op_e            alloc_op,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic [TAG_W-1:0]  alloc_qk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  input  logic              grant,
  output logic              busy,
  output logic              req,
  output logic [DATA_W-1:0] result
);

  slot_st_e          st_q;
  fu_op_e            op_q;
  logic [DATA_W-1:0] vj_q, vk_q, res_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [CNT_W-1:0]  cnt_q;

  // Named internal events.
  logic             qj_hit, qk_hit, opnd_ready;
  logic [CNT_W-1:0] lat_sel;

  assign qj_hit     = bus_valid && (qj_q != '0) && (bus_tag == qj_q);
  assign qk_hit     = bus_valid && (qk_q != '0) && (bus_tag == qk_q);
  assign opnd_ready = (qj_q == '0) && (qk_q == '0);
  assign lat_sel    = op_q[0] ? CNT_W'(LAT_HI) : CNT_W'(LAT_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SL_IDLE;
      op_q  <= OP_ADD;
      vj_q  <= '0;
      vk_q  <= '0;
      qj_q  <= '0;
      qk_q  <= '0;
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      case (st_q)
        SL_IDLE: begin
          if (alloc) begin
            st_q <= SL_WAIT;
            op_q <= alloc_op;
            vj_q <= alloc_vj;
            qj_q <= alloc_qj;
            vk_q <= alloc_vk;
            qk_q <= alloc_qk;
          end
        end
        SL_WAIT: begin
          if (qj_hit) begin
            vj_q <= bus_value;
            qj_q <= '0;
          end
          if (qk_hit) begin
            vk_q <= bus_value;
            qk_q <= '0;
          end
          if (opnd_ready) begin
            st_q  <= SL_EXEC;
            cnt_q <= lat_sel;
          end
        end
        SL_EXEC: begin
          if (cnt_q == CNT_W'(1)) begin
            st_q  <= SL_DONE;
            res_q <= fu_compute(op_q, vj_q, vk_q);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          if (grant) st_q <= SL_IDLE;
        end
      endcase
    end
  end

  assign busy   = (st_q != SL_IDLE);
  assign req    = (st_q == SL_DONE);
  assign result = res_q;

  p_exec_operands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_EXEC) |-> (qj_q == '0 && qk_q == '0));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_DONE && !grant) |=> (st_q == SL_DONE && $stable(res_q)));

  p_alloc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (st_q == SL_IDLE));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_DONE && grant) |=> (st_q == SL_IDLE));

endmodule

// File: rtl/reg_stat_table.sv
module reg_stat_table
  import tomasulo_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int TAG_W = 3,
  localparam int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  input  logic              set_en,
  input  logic [AW-1:0]     set_idx,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic [AW-1:0]     ra_idx,
  output logic [DATA_W-1:0] ra_val,
  output logic [TAG_W-1:0]  ra_tag,
  input  logic [AW-1:0]     rb_idx,
  output logic [DATA_W-1:0] rb_val,
  output logic [TAG_W-1:0]  rb_tag,
  input  logic [AW-1:0]     rc_idx,
  output logic [DATA_W-1:0] rc_val,
  output logic              rc_busy
);

  logic [DATA_W-1:0] val_q [NREG];
  logic [TAG_W-1:0]  tag_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        val_q[i] <= DATA_W'(i);
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (bus_valid && tag_q[i] != '0 && tag_q[i] == bus_tag) begin
          val_q[i] <= bus_value;
          tag_q[i] <= '0;
        end
        // A new writer takes ownership over a same-cycle retirement.
        if (set_en && set_idx == AW'(i)) tag_q[i] <= set_tag;
      end
    end
  end

  assign ra_val  = val_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign rb_val  = val_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rc_val  = val_q[rc_idx];
  assign rc_busy = (tag_q[rc_idx] != '0);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_bus_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && tag_q[g] != '0 && tag_q[g] == bus_tag && !(set_en && set_idx == AW'(g)))
      |=> (tag_q[g] == '0 && val_q[g] == $past(bus_value)));

    p_new_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && set_idx == AW'(g)) |=> (tag_q[g] == $past(set_tag)));

    p_stale_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && tag_q[g] != bus_tag && !(set_en && set_idx == AW'(g)))
      |=> $stable(val_q[g]) && $stable(tag_q[g]));
  end

endmodule

// File: rtl/tomasulo_core.sv
module tomasulo_core
  import tomasulo_pkg::*;
#(
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int NREG    = 8,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int N_RS   = N_ADD + N_MUL,
  localparam int TAG_W  = $clog2(N_RS + 1),
  localparam int AW     = $clog2(NREG),
  localparam int IW     = $clog2(N_RS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [AW-1:0]     iss_dst,
  input  logic [AW-1:0]     iss_src1,
  input  logic [AW-1:0]     iss_src2,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_value,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_value,
  output logic              rd_busy
);

  fu_op_e            op_in;
  logic [N_RS-1:0]   rs_busy, rs_req, rs_grant, alloc_vec;
  logic [DATA_W-1:0] rs_res [N_RS];
  logic              want_long, pick_found, iss_fire;
  logic [IW-1:0]     pick_idx;
  logic [DATA_W-1:0] rf_val1, rf_val2, opnd_vj, opnd_vk;
  logic [TAG_W-1:0]  rf_tag1, rf_tag2, opnd_qj, opnd_qk;
  logic [IW-1:0]     arb_idx;
  logic              arb_any;

  assign op_in     = fu_op_e'(iss_op);
  assign want_long = fu_is_long(op_in);

  // Lowest free slot of the wanted class.
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int i = N_RS - 1; i >= 0; i--) begin
      if (!rs_busy[i] && ((i >= N_ADD) == want_long)) begin
        pick_found = 1'b1;
        pick_idx   = IW'(i);
      end
    end
  end

  assign iss_ready = pick_found;
  assign iss_tag   = pick_found ? TAG_W'(int'(pick_idx) + 1) : '0;
  assign iss_fire  = iss_valid && pick_found;
  assign alloc_vec = iss_fire ? (N_RS'(1) << pick_idx) : '0;

  // Operand resolution: register value, same-cycle bus value, or tag.
  always_comb begin
    if (rf_tag1 == '0) begin
      opnd_vj = rf_val1;
      opnd_qj = '0;
    end else if (cdb_valid && cdb_tag == rf_tag1) begin
      opnd_vj = cdb_value;
      opnd_qj = '0;
    end else begin
      opnd_vj = '0;
      opnd_qj = rf_tag1;
    end
    if (rf_tag2 == '0) begin
      opnd_vk = rf_val2;
      opnd_qk = '0;
    end else if (cdb_valid && cdb_tag == rf_tag2) begin
      opnd_vk = cdb_value;
      opnd_qk = '0;
    end else begin
      opnd_vk = '0;
      opnd_qk = rf_tag2;
    end
  end

  reg_stat_table #(.NREG(NREG), .TAG_W(TAG_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (cdb_valid),
    .bus_tag   (cdb_tag),
    .bus_value (cdb_value),
    .set_en    (iss_fire),
    .set_idx   (iss_dst),
    .set_tag   (iss_tag),
    .ra_idx    (iss_src1),
    .ra_val    (rf_val1),
    .ra_tag    (rf_tag1),
    .rb_idx    (iss_src2),
    .rb_val    (rf_val2),
    .rb_tag    (rf_tag2),
    .rc_idx    (rd_addr),
    .rc_val    (rd_value),
    .rc_busy   (rd_busy)
  );

  for (genvar g = 0; g < N_RS; g++) begin : g_rs
    localparam int LO = (g < N_ADD) ? LAT_ADD : LAT_MUL;
    localparam int HI = (g < N_ADD) ? LAT_ADD : LAT_DIV;
    rs_slot #(.TAG_W(TAG_W), .LAT_LO(LO), .LAT_HI(HI)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_vec[g]),
      .alloc_op  (op_in),
      .alloc_vj  (opnd_vj),
      .alloc_qj  (opnd_qj),
      .alloc_vk  (opnd_vk),
      .alloc_qk  (opnd_qk),
      .bus_valid (cdb_valid),
      .bus_tag   (cdb_tag),
      .bus_value (cdb_value),
      .grant     (rs_grant[g]),
      .busy      (rs_busy[g]),
      .req       (rs_req[g]),
      .result    (rs_res[g])
    );
  end

  cdb_arbiter #(.N(N_RS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rs_req),
    .grant (rs_grant),
    .any   (arb_any),
    .idx   (arb_idx)
  );

  assign cdb_valid = arb_any;
  assign cdb_tag   = arb_any ? TAG_W'(int'(arb_idx) + 1) : '0;
  assign cdb_value = rs_res[arb_idx];

  p_short_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rs_req[N_ADD-1:0]) |-> (rs_grant[N_RS-1:N_ADD] == '0));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&rs_busy[N_ADD-1:0]) && !want_long) |-> !iss_ready);

  p_alloc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec) && ((alloc_vec & rs_busy) == '0));

  p_bypass_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && cdb_valid && rf_tag1 == cdb_tag && rf_tag1 != '0) |-> (opnd_qj == '0));

endmodule

// File: tb/test_tomasulo_core.sv
module test_tomasulo_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = 2'd0;
  logic [2:0]  iss_dst = 3'd0, iss_src1 = 3'd0, iss_src2 = 3'd0;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_value;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_value;
  logic        rd_busy;

  tomasulo_core i_tomasulo_core (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_value(cdb_value), .rd_addr(rd_addr),
    .rd_value(rd_value), .rd_busy(rd_busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [2:0]  tag;
    logic [31:0] val;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] arch[8];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  int          hit;

  // Sequential reference for one operation.
  function automatic logic [31:0] ref_op(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [63:0] p;
    if (op == 2'd0) return a + b;
    if (op == 2'd1) return a + (~b) + 32'd1;
    if (op == 2'd2) begin
      p = {32'd0, a} * {32'd0, b};
      return p[31:0];
    end
    if (b == 32'd0) return 32'hFFFF_FFFF;
    return a / b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every broadcast must match an outstanding expected item.
  always @(negedge clk) begin
    if (rst_n && cdb_valid) begin
      hit = -1;
      for (int i = 0; i < sb.size(); i++)
        if (hit < 0 && sb[i].tag == cdb_tag) hit = i;
      if (hit < 0) begin
        chk("R2 unexpected bus tag", {29'd0, cdb_tag}, 32'd0);
      end else begin
        chk("R2 broadcast value", cdb_value, sb[hit].val);
        sb.delete(hit);
      end
    end
  end

  // Driver: issue one operation, waiting while no slot is free.
  task automatic issue(input logic [1:0] op, input int d, input int s1, input int s2,
                       output logic [2:0] tag);
    exp_t e;
    @(negedge clk);
    iss_valid = 1'b1;
    iss_op = op;
    iss_dst = 3'(d);
    iss_src1 = 3'(s1);
    iss_src2 = 3'(s2);
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    tag = iss_tag;
    e.tag = tag;
    e.val = ref_op(op, arch[s1], arch[s2]);
    arch[d] = e.val;
    sb.push_back(e);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic probe_ready(input logic [1:0] op, output logic rdy);
    @(negedge clk);
    iss_op = op;
    #1 rdy = iss_ready;
  endtask

  task automatic peek(input int a, output logic [31:0] v, output logic b);
    rd_addr = 3'(a);
    #1;
    v = rd_value;
    b = rd_busy;
  endtask

  // Counts edges after the issue edge until the given tag is broadcast.
  task automatic measure(input logic [2:0] tag, output int k);
    k = 0;
    forever begin
      @(negedge clk);
      if (cdb_valid && cdb_tag == tag) break;
      k++;
      if (k > 200) break;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && sb.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R2 all results broadcast", 32'(sb.size()), 32'd0);
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    logic b;
    for (int r = 0; r < 8; r++) begin
      peek(r, v, b);
      chk(req, v, arch[r]);
      chk(req, {31'd0, b}, 32'd0);
    end
  endtask

  initial begin : main
    logic [2:0] t0, t1, t2, t3;
    logic [31:0] v, old_r1, exp_v;
    logic b, rdy;
    int k;
    logic [31:0] lfsr;

    for (int r = 0; r < 8; r++) arch[r] = 32'(r);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 bus idle", {31'd0, cdb_valid}, 32'd0);
    probe_ready(2'd0, rdy); chk("R1 short ready", {31'd0, rdy}, 32'd1);
    probe_ready(2'd3, rdy); chk("R1 long ready", {31'd0, rdy}, 32'd1);
    check_regs("R1 register reset");

    // R3: latency per opcode with ready operands
    issue(2'd0, 1, 2, 3, t0); measure(t0, k); chk("R3 add latency", 32'(k), 32'd3);
    drain();
    issue(2'd1, 2, 7, 3, t0); measure(t0, k); chk("R3 sub latency", 32'(k), 32'd3);
    drain();
    issue(2'd2, 3, 6, 7, t0); measure(t0, k); chk("R3 mul latency", 32'(k), 32'd11);
    drain();
    issue(2'd3, 4, 3, 2, t0); measure(t0, k); chk("R3 div latency", 32'(k), 32'd41);
    drain();
    issue(2'd3, 6, 5, 0, t0); drain();   // R2: zero divisor gives all ones
    peek(6, v, b); chk("R2 divide by zero", v, 32'hFFFF_FFFF);
    check_regs("R6 registers after single ops");

    // R4 / R5: fill slots behind a long divide
    issue(2'd3, 4, 7, 2, t0); chk("R4 long tag", {29'd0, t0}, 32'd4);
    issue(2'd0, 1, 4, 0, t1); chk("R4 first short tag", {29'd0, t1}, 32'd1);
    issue(2'd0, 3, 4, 1, t2); chk("R4 second short tag", {29'd0, t2}, 32'd2);
    issue(2'd1, 6, 4, 4, t3); chk("R4 third short tag", {29'd0, t3}, 32'd3);
    probe_ready(2'd0, rdy); chk("R4 short stall", {31'd0, rdy}, 32'd0);
    issue(2'd2, 5, 4, 4, t3); chk("R4 second long tag", {29'd0, t3}, 32'd5);
    probe_ready(2'd2, rdy); chk("R4 long stall", {31'd0, rdy}, 32'd0);
    peek(1, v, b); chk("R6 pending mark", {31'd0, b}, 32'd1);
    drain();
    check_regs("R5 dependent chain results");

    // R7: later writer owns the destination
    issue(2'd3, 5, 7, 3, t0);
    issue(2'd0, 5, 1, 2, t1);
    exp_v = arch[5];
    measure(t1, k);
    @(negedge clk);
    peek(5, v, b);
    chk("R7 later writer value", v, exp_v);
    chk("R6 mark cleared", {31'd0, b}, 32'd0);
    drain();
    peek(5, v, b); chk("R7 stale writer ignored", v, exp_v);

    // R10: copied operand not disturbed by later write
    old_r1 = arch[1];
    issue(2'd3, 4, 7, 3, t0);
    issue(2'd2, 5, 4, 1, t1);
    issue(2'd0, 1, 2, 3, t2);
    exp_v = ref_op(2'd2, ref_op(2'd3, arch[7], arch[3]), old_r1);
    drain();
    peek(5, v, b); chk("R10 copied operand", v, exp_v);

    // R8: short and long finish on the same edge
    issue(2'd2, 6, 2, 3, t0);
    repeat (7) @(posedge clk);
    issue(2'd0, 7, 1, 2, t1);
    repeat (4) @(negedge clk);
    chk("R8 short wins bus", {28'd0, cdb_valid, cdb_tag}, {28'd0, 1'b1, t1});
    @(negedge clk);
    chk("R8 loser retries", {28'd0, cdb_valid, cdb_tag}, {28'd0, 1'b1, t0});
    drain();

    // R9: issue during the producer's broadcast
    issue(2'd0, 1, 2, 3, t0);
    repeat (3) @(posedge clk);
    issue(2'd0, 6, 1, 1, t1);
    measure(t1, k);
    chk("R9 bypass start", 32'(k), 32'd3);
    drain();
    check_regs("R9 bypass results");

    // R2 / R6: mixed stream
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      issue(lfsr[1:0], int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]), t0);
    end
    drain();
    check_regs("R6 mixed stream registers");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule